// File: doc/BRIEF.md
# Write-Once Watchdog Timer

This block is a watchdog timer that counts strobes of a slow reference tick, about 1 kHz, in the system clock domain. If software does not service it within the selected window, the block raises a one-cycle reset request. Software services the watchdog by writing any value to a read-only status address. The block has a small register interface with two decoded addresses.

The enable bit and the timeout-select bit sit together in an options register. That register accepts only its first write after reset, so a runaway program cannot switch the watchdog off or stretch its window. Two sideband inputs report debug mode and low-power stop mode. The counter holds its value in debug mode and is forced to zero during stop mode. A sticky cause flag records that the watchdog fired. Only the power-on reset clears this flag, so it survives the system reset that the watchdog itself triggers.

Top module: `wdg_top`

## Requirements
- R1: After reset, the options read data is 0x03. Bit 0 (enable) is 1, bit 1 (long select) is 1 and bit 7 (lock) is 0. The reset request output is low.
- R2: A qualifying tick is one on which the watchdog is enabled and neither debug nor stop mode is active. The reset request fires on the qualifying tick that brings the count since the last clear to 2^5 = 32 when bit 1 is 0, or to 2^8 = 256 when bit 1 is 1.
- R3: A write of any data to the status address (0x1) clears the counter. The status read data is not altered by that write.
- R4: The first write to the options address (0x2) after reset loads bit 0 into enable and bit 1 into long select, and sets the lock (read bit 7). Every later write is ignored until the next reset.
- R5: The first options write also clears the counter.
- R6: While the debug input is high, the counter does not advance.
- R7: While the stop input is high, the counter is zero. Counting restarts from zero when stop mode ends.
- R8: A first options write with bit 0 clear disables the watchdog until the next reset, and no reset request is made.
- R9: A status write in the same cycle as the terminal tick wins. No request is made and the count restarts.
- R10: The reset request lasts one clock cycle. It sets status bit 0, which stays set through `rst_n` and is cleared only by `por_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| por_n | input | 1 | Asynchronous active-low power-on reset; also resets everything `rst_n` resets |
| tick | input | 1 | Single-cycle reference tick strobe |
| dbg_mode | input | 1 | High while debug mode is active |
| stop_mode | input | 1 | High while stop mode is active |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | ADDR_W | Register address for reads and writes |
| bus_wdata | input | 8 | Write data |
| rd_data | output | 8 | Combinational read data for `bus_addr` |
| rst_req | output | 1 | One-cycle watchdog reset request |

## Verification
The assertions assume that `bus_wr` is a single-cycle strobe with a stable address. They also assume that, for as long as the block runs without a further reset, nothing drives the block's own reset from `rst_req`. The bench keeps to this: it drives every write for exactly one cycle and only observes `rst_req`. The freeze property assumes that no write occurs while debug mode is held, and the stimulus writes only while debug is low. The bench sweeps every service point inside the short window and a spread of points inside the long window, and it predicts each request from the tick count alone.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  localparam int OPT_EN_BIT    = 0;
  localparam int OPT_LONG_BIT  = 1;
  localparam int OPT_LOCK_BIT  = 7;
  localparam int STAT_CAUSE_BIT = 0;
  localparam int DATA_W        = 8;

  typedef struct packed {
    logic en;
    logic long_sel;
    logic locked;
  } wdg_opt_t;
endpackage

// File: rtl/wdg_rst_sync.sv
module wdg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/wdg_regs.sv
module wdg_regs
  import wdg_pkg::*;
#(
  parameter int                ADDR_W    = 4,
  parameter logic [ADDR_W-1:0] OPT_ADDR  = 4'h2,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 4'h1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              cause,
  output wdg_opt_t          opt,
  output logic              cnt_clr,
  output logic [DATA_W-1:0] rd_data
);
  wdg_opt_t opt_q, opt_d;
  logic     opt_load;
  logic     stat_wr;

  always_comb begin
    stat_wr  = bus_wr && (bus_addr == STAT_ADDR);
    opt_load = bus_wr && (bus_addr == OPT_ADDR) && !opt_q.locked;
    opt_d    = opt_q;
    if (opt_load) begin
      opt_d.en       = bus_wdata[OPT_EN_BIT];
      opt_d.long_sel = bus_wdata[OPT_LONG_BIT];
      opt_d.locked   = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opt_q.en       <= 1'b1;
      opt_q.long_sel <= 1'b1;
      opt_q.locked   <= 1'b0;
    end else if (opt_load) begin
      opt_q <= opt_d;
    end
  end

  always_comb begin
    rd_data = '0;
    if (bus_addr == OPT_ADDR) begin
      rd_data[OPT_EN_BIT]   = opt_q.en;
      rd_data[OPT_LONG_BIT] = opt_q.long_sel;
      rd_data[OPT_LOCK_BIT] = opt_q.locked;
    end else if (bus_addr == STAT_ADDR) begin
      rd_data[STAT_CAUSE_BIT] = cause;
    end
  end

  assign opt     = opt_q;
  assign cnt_clr = stat_wr || opt_load;
endmodule

// File: rtl/wdg_counter.sv
module wdg_counter
  import wdg_pkg::*;
#(
  parameter int SHORT_LOG2 = 5,
  parameter int LONG_LOG2  = 8
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     tick,
  input  logic     dbg_mode,
  input  logic     stop_mode,
  input  wdg_opt_t opt,
  input  logic     cnt_clr,
  output logic     fire
);
  localparam int              CNT_W     = LONG_LOG2;
  localparam logic [CNT_W-1:0] SHORT_END = CNT_W'((1 << SHORT_LOG2) - 1);
  localparam logic [CNT_W-1:0] LONG_END  = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] term_m1;
  logic             qual;
  logic             zero;
  logic             at_end;
  logic             cnt_en;

  always_comb begin
    term_m1 = opt.long_sel ? LONG_END : SHORT_END;
    qual    = tick && opt.en && !dbg_mode && !stop_mode;
    zero    = cnt_clr || stop_mode || !opt.en;
    at_end  = (cnt_q == term_m1);
    fire    = qual && at_end && !zero;
    cnt_en  = zero || qual;
    if (zero || at_end) cnt_d = '0;
    else                cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/wdg_cause.sv
module wdg_cause (
  input  logic clk,
  input  logic rst_n,
  input  logic por_n,
  input  logic fire,
  output logic rst_req,
  output logic cause
);
  logic req_q, cause_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= fire;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)    cause_q <= 1'b0;
    else if (fire) cause_q <= 1'b1;
  end

  assign rst_req = req_q;
  assign cause   = cause_q;
endmodule

// File: rtl/wdg_top.sv
module wdg_top
  import wdg_pkg::*;
#(
  parameter int                ADDR_W     = 4,
  parameter logic [ADDR_W-1:0] OPT_ADDR   = 4'h2,
  parameter logic [ADDR_W-1:0] STAT_ADDR  = 4'h1,
  parameter int                SHORT_LOG2 = 5,
  parameter int                LONG_LOG2  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              por_n,
  input  logic              tick,
  input  logic              dbg_mode,
  input  logic              stop_mode,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        rd_data,
  output logic              rst_req
);
  logic     sys_rst_n, por_s_n;
  logic     cnt_clr, fire, cause;
  wdg_opt_t opt;
  logic     any_rst_n;

  assign any_rst_n = rst_n && por_n;

  wdg_rst_sync #(.STAGES(2)) sys_sync_i (.clk(clk), .arst_n(any_rst_n), .srst_n(sys_rst_n));
  wdg_rst_sync #(.STAGES(2)) por_sync_i (.clk(clk), .arst_n(por_n),     .srst_n(por_s_n));

  wdg_regs #(.ADDR_W(ADDR_W), .OPT_ADDR(OPT_ADDR), .STAT_ADDR(STAT_ADDR)) regs_i (
    .clk(clk), .rst_n(sys_rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .cause(cause), .opt(opt), .cnt_clr(cnt_clr), .rd_data(rd_data)
  );

  wdg_counter #(.SHORT_LOG2(SHORT_LOG2), .LONG_LOG2(LONG_LOG2)) cnt_i (
    .clk(clk), .rst_n(sys_rst_n), .tick(tick), .dbg_mode(dbg_mode),
    .stop_mode(stop_mode), .opt(opt), .cnt_clr(cnt_clr), .fire(fire)
  );

  wdg_cause cause_i (
    .clk(clk), .rst_n(sys_rst_n), .por_n(por_s_n), .fire(fire),
    .rst_req(rst_req), .cause(cause)
  );
endmodule

// File: rtl/wdg_checker.sv
module wdg_checker #(
  parameter int                ADDR_W    = 4,
  parameter logic [ADDR_W-1:0] OPT_ADDR  = 4'h2,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 4'h1,
  parameter int                CNT_W     = 8
) (
  input logic              clk,
  input logic              srst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              dbg_mode,
  input logic              stop_mode,
  input logic              rst_req,
  input logic              cause,
  input logic              locked,
  input logic              en,
  input logic              long_sel,
  input logic [CNT_W-1:0]  cnt
);
  // R9: a status write suppresses any request in the following cycle
  a_r9_service_wins: assert property (@(posedge clk) disable iff (!srst_n)
    (bus_wr && bus_addr == STAT_ADDR) |=> !rst_req);

  // R10: request is a single-cycle pulse and the cause flag is set with it
  a_r10_single_pulse: assert property (@(posedge clk) disable iff (!srst_n)
    rst_req |=> !rst_req);
  a_r10_cause_set: assert property (@(posedge clk) disable iff (!srst_n)
    rst_req |-> cause);

  // R4: once locked, options writes change nothing
  a_r4_lock_holds: assert property (@(posedge clk) disable iff (!srst_n)
    locked |=> (locked && $stable(en) && $stable(long_sel)));

  // R6: counter holds in debug mode when no write clears it
  a_r6_debug_freeze: assert property (@(posedge clk) disable iff (!srst_n)
    (dbg_mode && !stop_mode && !bus_wr) |=> $stable(cnt));

  // R7: stop mode forces the counter to zero
  a_r7_stop_zero: assert property (@(posedge clk) disable iff (!srst_n)
    stop_mode |=> (cnt == '0));

  // R8: a disabled watchdog never requests
  a_r8_disabled_quiet: assert property (@(posedge clk) disable iff (!srst_n)
    (!en && !$rose(srst_n)) |=> !rst_req);
endmodule

bind wdg_top wdg_checker #(
  .ADDR_W(ADDR_W), .OPT_ADDR(OPT_ADDR), .STAT_ADDR(STAT_ADDR), .CNT_W(LONG_LOG2)
) chk_i (
  .clk(clk), .srst_n(sys_rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .dbg_mode(dbg_mode), .stop_mode(stop_mode), .rst_req(rst_req), .cause(cause),
  .locked(opt.locked), .en(opt.en), .long_sel(opt.long_sel), .cnt(cnt_i.cnt_q)
);

// File: tb/wdg_top_tb_top.sv
module wdg_top_tb_top;
  localparam logic [3:0] OPT_A  = 4'h2;
  localparam logic [3:0] STAT_A = 4'h1;

  logic       clk = 1'b0;
  logic       rst_n, por_n, tick, dbg_mode, stop_mode, bus_wr;
  logic [3:0] bus_addr;
  logic [7:0] bus_wdata, rd_data;
  logic       rst_req;

  int checks = 0;
  int failures = 0;
  int req_cnt = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  wdg_top dut_i (
    .clk(clk), .rst_n(rst_n), .por_n(por_n), .tick(tick), .dbg_mode(dbg_mode),
    .stop_mode(stop_mode), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .rd_data(rd_data), .rst_req(rst_req)
  );

  always @(negedge clk) if (rst_req) req_cnt++;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset(input bit power);
    @(negedge clk);
    rst_n = 1'b0;
    if (power) por_n = 1'b0;
    idle(3);
    rst_n = 1'b1;
    por_n = 1'b1;
    idle(4);
    req_cnt = 0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d, input bit with_tick);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d; tick = with_tick;
    @(negedge clk);
    bus_wr = 1'b0; tick = 1'b0; bus_addr = 4'h0;
    @(negedge clk);
  endtask

  task automatic rd(input logic [3:0] a, output int v);
    bus_addr = a;
    #2 v = int'(rd_data);
    bus_addr = 4'h0;
    @(negedge clk);
  endtask

  // expect no request for n-1 ticks, then one on the n-th
  task automatic window(input string req, input int n);
    req_cnt = 0;
    ticks(n - 1);
    idle(1);
    chk(req, req_cnt, 0);
    ticks(1);
    idle(1);
    chk(req, req_cnt, 1);
  endtask

  initial begin
    int v;
    rst_n = 1'b0; por_n = 1'b0; tick = 1'b0; dbg_mode = 1'b0; stop_mode = 1'b0;
    bus_wr = 1'b0; bus_addr = 4'h0; bus_wdata = 8'h00;
    do_reset(1'b1);

    // R1 reset state
    rd(OPT_A, v);  chk("R1 options", v, 8'h03);
    rd(STAT_A, v); chk("R1 status", v, 0);
    chk("R1 rst_req", int'(rst_req), 0);

    // R2 long default window, R10 cause flag
    window("R2 long", 256);
    rd(STAT_A, v); chk("R10 cause set", v, 1);

    // R3 status write clears counter, contents unchanged
    ticks(100);
    wr(STAT_A, 8'hFF, 1'b0);
    rd(STAT_A, v); chk("R3 status unchanged", v, 1);
    window("R3 cleared", 256);

    // R10 cause survives system reset, cleared by power-on reset
    do_reset(1'b0);
    rd(STAT_A, v); chk("R10 cause after rst_n", v, 1);
    do_reset(1'b1);
    rd(STAT_A, v); chk("R10 cause after por_n", v, 0);

    // R5 first options write clears counter; R4 load and lock
    ticks(20);
    wr(OPT_A, 8'h01, 1'b0);
    rd(OPT_A, v); chk("R4 locked short", v, 8'h81);
    window("R5 short after clear", 32);

    // R4 second write ignored
    wr(OPT_A, 8'h02, 1'b0);
    rd(OPT_A, v); chk("R4 second write ignored", v, 8'h81);
    window("R4 still short", 32);

    // R6 debug freeze
    wr(STAT_A, 8'h00, 1'b0);
    req_cnt = 0;
    ticks(10);
    dbg_mode = 1'b1;
    ticks(50);
    dbg_mode = 1'b0;
    idle(1);
    chk("R6 no request in debug", req_cnt, 0);
    window("R6 resume", 22);

    // R7 stop clears counter
    wr(STAT_A, 8'h00, 1'b0);
    ticks(10);
    stop_mode = 1'b1;
    ticks(40);
    stop_mode = 1'b0;
    idle(1);
    window("R7 restart from zero", 32);

    // R9 same-cycle service wins
    wr(STAT_A, 8'h00, 1'b0);
    req_cnt = 0;
    ticks(31);
    wr(STAT_A, 8'h5A, 1'b1);
    idle(1);
    chk("R9 no request", req_cnt, 0);
    window("R9 restart", 32);

    // R2 sweep of every service point in the short window
    for (int k = 0; k < 32; k++) begin
      wr(STAT_A, 8'h00, 1'b0);
      ticks(k);
      wr(STAT_A, 8'h00, 1'b0);
      window("R2 short sweep", 32);
    end

    // R2 long window at spread service points
    do_reset(1'b1);
    wr(OPT_A, 8'h03, 1'b0);
    rd(OPT_A, v); chk("R4 locked long", v, 8'h83);
    for (int k = 0; k < 256; k += 85) begin
      wr(STAT_A, 8'h00, 1'b0);
      ticks(k);
      wr(STAT_A, 8'h00, 1'b0);
      window("R2 long sweep", 256);
    end

    // R8 disable permanently
    do_reset(1'b1);
    wr(OPT_A, 8'h02, 1'b0);
    rd(OPT_A, v); chk("R8 disabled options", v, 8'h82);
    wr(OPT_A, 8'h03, 1'b0);
    req_cnt = 0;
    ticks(300);
    idle(1);
    chk("R8 no request", req_cnt, 0);
    rd(STAT_A, v); chk("R8 cause clear", v, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog timeout actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule